// File: doc/BRIEF.md
# Link Word Error Classifier and Logger

This block sits behind the receive side of a serial link test setup. Each cycle it may be handed a received parallel word and the word that should have arrived in that slot. It compares the two and turns every mismatch into a logged event. An isolated bad word becomes a single-flip record or a multi-flip record, depending on how many bits differ. A run of two or more consecutive bad words becomes one frame-loss record that gives the run length. Classification runs only while the receiver reports that it holds frame lock.

Each record carries a kind code, a timestamp and a field whose meaning depends on the kind. The timestamp is the value of a free-running cycle counter at the first bad word of the event. Records leave on a valid/ready stream and stay stable until they are taken. A record that finds the output still occupied is dropped, and a sticky overflow flag is raised. Three saturating counters give the number of events of each kind that have been classified, whether or not their records were delivered.

Top module: `link_err_logger`

## Requirements
- R1: A synchronous active-high reset clears the record output (valid low), all three event counters, the overflow flag, the timestamp counter and any pending or frame-loss state.
- R2: A bad word followed by a clean valid word (still locked) yields one record of kind 1 (single flip) when exactly one bit differs. Its field has the bit index in bits [IDXW-1:0] and a direction bit at position IDXW, where 1 means expected 1 / received 0 and 0 means expected 0 / received 1. IDXW = clog2(W), which is 5 for W = 32.
- R3: A bad word that differs in two or more bits, followed by a clean valid word, yields one record of kind 2 (multi flip) whose field is the number of differing bits.
- R4: Two or more consecutive bad valid words yield exactly one record of kind 3 (frame loss), sent after the first clean valid word. Its field is the number of bad words in the run, and its timestamp is that of the first bad word.
- R5: Valid words that arrive while lock is low produce no records. If lock drops while a single bad word is pending, that word is discarded. If lock drops during a frame loss, the frame-loss record is sent at once with the length counted so far.
- R6: The frame-loss length saturates at 2^LENW-1 and does not wrap.
- R7: While valid is high and ready is low, the valid, kind, timestamp and field outputs hold their values.
- R8: A record produced while the output holds an unaccepted record is dropped. The overflow flag then goes to 1 and stays at 1 until reset.
- R9: The single, multi and frame-loss counters each count classified events of their kind, including dropped ones. Each saturates at 2^CNTW-1.
- R10: The timestamp counter increments by one every clock after reset, starting from 0. A record's timestamp is the counter value in the cycle its first bad word is sampled.
- R11: Cycles with the word strobe low neither end nor extend a pending word or a frame-loss run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_i | input | 1 | Receiver holds frame lock |
| word_vld_i | input | 1 | Received/expected word pair is valid this cycle |
| rx_word_i | input | W | Received word |
| exp_word_i | input | W | Expected word for the same slot |
| rec_ready_i | input | 1 | Collector accepts the record |
| rec_valid_o | output | 1 | Record available |
| rec_kind_o | output | 2 | 1 single flip, 2 multi flip, 3 frame loss |
| rec_time_o | output | TSW | Timestamp of the first bad word |
| rec_field_o | output | FW | Kind-specific field (bit index and direction, bit count, or run length) |
| overflow_o | output | 1 | Sticky: a record was dropped |
| cnt_single_o | output | CNTW | Single-flip events, saturating |
| cnt_multi_o | output | CNTW | Multi-flip events, saturating |
| cnt_loss_o | output | CNTW | Frame-loss events, saturating |

## Verification
The assertions check the following on every cycle: records hold steady under backpressure; overflow is sticky and rises only when a waiting record is refused; counters never go down; the timestamp advances by one per clock; and kind and field values stay within legal ranges (a multi-flip count is at least 2, and a frame-loss length is at least 2). The timestamp advance is checked on an internal counter that the bind reaches. Only the bench scenarios can show that a given word pattern leads to the right kind, bit index, direction and run length. The same holds for the effects of lock loss, gaps in the strobe, saturation of the run length, and the choice of which record is dropped.

// File: rtl/lel_pkg.sv
package lel_pkg;

    // Record kind codes seen on rec_kind_o
    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_SINGLE = 2'd1,
        K_MULTI  = 2'd2,
        K_LOSS   = 2'd3
    } kind_t;

    // Classifier states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_LOSS = 2'd2
    } cls_state_t;

    localparam int NUM_KINDS = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lel_word_cmp.sv
// Bitwise comparison: differing-bit count, position and direction of a flip
module lel_word_cmp #(
    parameter int W    = 32,
    parameter int CW   = 6,
    parameter int IDXW = 5
) (
    input  logic [W-1:0]    rx_i,
    input  logic [W-1:0]    exp_i,
    output logic [CW-1:0]   diff_cnt_o,
    output logic [IDXW-1:0] diff_idx_o,
    output logic            diff_dir_o
);
    logic [W-1:0] diff;

    assign diff = rx_i ^ exp_i;

    always_comb begin
        diff_cnt_o = '0;
        diff_idx_o = '0;
        diff_dir_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (diff[i]) begin
                diff_cnt_o = diff_cnt_o + CW'(1);
                diff_idx_o = IDXW'(i);
                diff_dir_o = exp_i[i];   // 1: expected 1, got 0 (R2)
            end
        end
    end
endmodule

// File: rtl/lel_event_fsm.sv
// Event classifier: pending word, frame-loss run, record emission
module lel_event_fsm
    import lel_pkg::*;
#(
    parameter int CW   = 6,
    parameter int IDXW = 5,
    parameter int TSW  = 16,
    parameter int LENW = 8,
    parameter int FW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lock_i,
    input  logic            vld_i,
    input  logic [CW-1:0]   diff_cnt_i,
    input  logic [IDXW-1:0] diff_idx_i,
    input  logic            diff_dir_i,
    input  logic [TSW-1:0]  ts_i,
    output logic            emit_o,
    output kind_t           emit_kind_o,
    output logic [TSW-1:0]  emit_time_o,
    output logic [FW-1:0]   emit_field_o
);
    cls_state_t      st_q, st_d;
    logic [TSW-1:0]  ts_hold_q, ts_hold_d;
    kind_t           pk_q, pk_d;
    logic [FW-1:0]   pf_q, pf_d;
    logic [LENW-1:0] len_q, len_d;

    logic            word_bad;
    kind_t           cur_kind;
    logic [FW-1:0]   cur_field;

    assign word_bad  = (diff_cnt_i != '0);
    assign cur_kind  = (diff_cnt_i == CW'(1)) ? K_SINGLE : K_MULTI;
    assign cur_field = (diff_cnt_i == CW'(1)) ? FW'({diff_dir_i, diff_idx_i})
                                              : FW'(diff_cnt_i);

    always_comb begin
        st_d         = st_q;
        ts_hold_d    = ts_hold_q;
        pk_d         = pk_q;
        pf_d         = pf_q;
        len_d        = len_q;
        emit_o       = 1'b0;
        emit_kind_o  = K_NONE;
        emit_time_o  = ts_hold_q;
        emit_field_o = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (lock_i && vld_i && word_bad) begin
                    st_d      = ST_PEND;
                    ts_hold_d = ts_i;          // R10
                    pk_d      = cur_kind;
                    pf_d      = cur_field;
                end
            end
            ST_PEND: begin
                if (!lock_i) begin
                    st_d = ST_IDLE;            // R5: pending word discarded
                end else if (vld_i) begin
                    if (word_bad) begin
                        st_d  = ST_LOSS;       // R4
                        len_d = LENW'(2);
                    end else begin
                        st_d         = ST_IDLE; // R2, R3
                        emit_o       = 1'b1;
                        emit_kind_o  = pk_q;
                        emit_field_o = pf_q;
                    end
                end
            end
            ST_LOSS: begin
                if (!lock_i || (vld_i && !word_bad)) begin
                    st_d         = ST_IDLE;    // R4, R5
                    emit_o       = 1'b1;
                    emit_kind_o  = K_LOSS;
                    emit_field_o = FW'(len_q);
                end else if (vld_i && len_q != '1) begin
                    len_d = len_q + LENW'(1);  // R6 saturation
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            ts_hold_q <= '0;
            pk_q      <= K_NONE;
            pf_q      <= '0;
            len_q     <= '0;
        end else begin
            st_q      <= st_d;
            ts_hold_q <= ts_hold_d;
            pk_q      <= pk_d;
            pf_q      <= pf_d;
            len_q     <= len_d;
        end
    end
endmodule

// File: rtl/lel_rec_out.sv
// Single record holding stage with drop-on-busy and sticky overflow
module lel_rec_out
    import lel_pkg::*;
#(
    parameter int TSW = 16,
    parameter int FW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           emit_i,
    input  kind_t          emit_kind_i,
    input  logic [TSW-1:0] emit_time_i,
    input  logic [FW-1:0]  emit_field_i,
    input  logic           ready_i,
    output logic           valid_o,
    output kind_t          kind_o,
    output logic [TSW-1:0] time_o,
    output logic [FW-1:0]  field_o,
    output logic           overflow_o
);
    logic busy;

    assign busy = valid_o && !ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o    <= 1'b0;
            kind_o     <= K_NONE;
            time_o     <= '0;
            field_o    <= '0;
            overflow_o <= 1'b0;
        end else if (busy) begin
            if (emit_i) overflow_o <= 1'b1;   // R8: new record dropped
        end else begin
            valid_o <= emit_i;
            if (emit_i) begin
                kind_o  <= emit_kind_i;
                time_o  <= emit_time_i;
                field_o <= emit_field_i;
            end
        end
    end
endmodule

// File: rtl/lel_counters.sv
// Per-kind saturating event counters
module lel_counters
    import lel_pkg::*;
#(
    parameter int CNTW = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           emit_i,
    input  kind_t                          emit_kind_i,
    output logic [NUM_KINDS-1:0][CNTW-1:0] cnt_o
);
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
        logic [CNTW-1:0] c_q;
        always_ff @(posedge clk) begin
            if (rst)
                c_q <= '0;
            else if (emit_i && emit_kind_i == kind_t'(k + 1) && c_q != '1)
                c_q <= c_q + CNTW'(1);          // R9
        end
        assign cnt_o[k] = c_q;
    end
endmodule

// File: rtl/link_err_logger.sv
module link_err_logger
    import lel_pkg::*;
#(
    parameter  int W    = 32,
    parameter  int TSW  = 16,
    parameter  int LENW = 8,
    parameter  int CNTW = 16,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1,
    localparam int CW   = $clog2(W + 1),
    localparam int FW   = max3(IDXW + 1, CW, LENW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lock_i,
    input  logic            word_vld_i,
    input  logic [W-1:0]    rx_word_i,
    input  logic [W-1:0]    exp_word_i,
    input  logic            rec_ready_i,
    output logic            rec_valid_o,
    output logic [1:0]      rec_kind_o,
    output logic [TSW-1:0]  rec_time_o,
    output logic [FW-1:0]   rec_field_o,
    output logic            overflow_o,
    output logic [CNTW-1:0] cnt_single_o,
    output logic [CNTW-1:0] cnt_multi_o,
    output logic [CNTW-1:0] cnt_loss_o
);
    logic [TSW-1:0]  ts_q;
    logic [CW-1:0]   diff_cnt;
    logic [IDXW-1:0] diff_idx;
    logic            diff_dir;
    logic            emit;
    kind_t           emit_kind;
    logic [TSW-1:0]  emit_time;
    logic [FW-1:0]   emit_field;
    kind_t           out_kind;
    logic [NUM_KINDS-1:0][CNTW-1:0] cnt;

    // R10: free-running timestamp
    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + TSW'(1);
    end

    lel_word_cmp #(.W(W), .CW(CW), .IDXW(IDXW)) cmp_i (
        .rx_i       (rx_word_i),
        .exp_i      (exp_word_i),
        .diff_cnt_o (diff_cnt),
        .diff_idx_o (diff_idx),
        .diff_dir_o (diff_dir)
    );

    lel_event_fsm #(.CW(CW), .IDXW(IDXW), .TSW(TSW), .LENW(LENW), .FW(FW)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .lock_i       (lock_i),
        .vld_i        (word_vld_i),
        .diff_cnt_i   (diff_cnt),
        .diff_idx_i   (diff_idx),
        .diff_dir_i   (diff_dir),
        .ts_i         (ts_q),
        .emit_o       (emit),
        .emit_kind_o  (emit_kind),
        .emit_time_o  (emit_time),
        .emit_field_o (emit_field)
    );

    lel_rec_out #(.TSW(TSW), .FW(FW)) out_i (
        .clk          (clk),
        .rst          (rst),
        .emit_i       (emit),
        .emit_kind_i  (emit_kind),
        .emit_time_i  (emit_time),
        .emit_field_i (emit_field),
        .ready_i      (rec_ready_i),
        .valid_o      (rec_valid_o),
        .kind_o       (out_kind),
        .time_o       (rec_time_o),
        .field_o      (rec_field_o),
        .overflow_o   (overflow_o)
    );

    lel_counters #(.CNTW(CNTW)) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .emit_i      (emit),
        .emit_kind_i (emit_kind),
        .cnt_o       (cnt)
    );

    assign rec_kind_o   = out_kind;
    assign cnt_single_o = cnt[0];
    assign cnt_multi_o  = cnt[1];
    assign cnt_loss_o   = cnt[2];
endmodule

// File: rtl/lel_checker.sv
module lel_checker #(
    parameter int W    = 32,
    parameter int TSW  = 16,
    parameter int FW   = 8,
    parameter int CNTW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            rec_valid_o,
    input logic            rec_ready_i,
    input logic [1:0]      rec_kind_o,
    input logic [TSW-1:0]  rec_time_o,
    input logic [FW-1:0]   rec_field_o,
    input logic            overflow_o,
    input logic [CNTW-1:0] cnt_single_o,
    input logic [CNTW-1:0] cnt_multi_o,
    input logic [CNTW-1:0] cnt_loss_o,
    input logic [TSW-1:0]  ts_q
);
    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_kind_o)
            && $stable(rec_time_o) && $stable(rec_field_o)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    a_r8_cause: assert property (@(posedge clk) disable iff (rst)
        (started && $rose(overflow_o)) |-> $past(rec_valid_o && !rec_ready_i));

    a_r9_monotonic: assert property (@(posedge clk) disable iff (rst)
        started |-> (cnt_single_o >= $past(cnt_single_o) && cnt_multi_o >= $past(cnt_multi_o)
                     && cnt_loss_o >= $past(cnt_loss_o)));

    a_r10_tick: assert property (@(posedge clk) disable iff (rst)
        started |-> ts_q == $past(ts_q) + TSW'(1));

    a_r2_kind_legal: assert property (@(posedge clk) disable iff (rst)
        rec_valid_o |-> rec_kind_o != 2'd0);

    a_r3_multi_range: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && rec_kind_o == 2'd2) |-> (rec_field_o >= FW'(2) && rec_field_o <= FW'(W)));

    a_r4_loss_len: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && rec_kind_o == 2'd3) |-> rec_field_o >= FW'(2));
endmodule

bind link_err_logger lel_checker #(.W(W), .TSW(TSW), .FW(FW), .CNTW(CNTW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .rec_valid_o  (rec_valid_o),
    .rec_ready_i  (rec_ready_i),
    .rec_kind_o   (rec_kind_o),
    .rec_time_o   (rec_time_o),
    .rec_field_o  (rec_field_o),
    .overflow_o   (overflow_o),
    .cnt_single_o (cnt_single_o),
    .cnt_multi_o  (cnt_multi_o),
    .cnt_loss_o   (cnt_loss_o),
    .ts_q         (ts_q)
);

// File: tb/link_err_logger_tb_top.sv
`timescale 1ns/1ps
module link_err_logger_tb_top;
    localparam int W    = 32;
    localparam int TSW  = 16;
    localparam int LENW = 6;
    localparam int CNTW = 4;
    localparam int FW   = 6;
    localparam logic [W-1:0] PAT   = 32'h3C3C_5A5A;
    localparam logic [W-1:0] CLEAN = 32'hDEAD_BEEF;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lock = 1'b0;
    logic            vld = 1'b0;
    logic [W-1:0]    rx_w = '0;
    logic [W-1:0]    exp_w = '0;
    logic            rec_ready = 1'b0;
    logic            rec_valid;
    logic [1:0]      rec_kind;
    logic [TSW-1:0]  rec_time;
    logic [FW-1:0]   rec_field;
    logic            overflow;
    logic [CNTW-1:0] cnt_single, cnt_multi, cnt_loss;

    typedef struct {
        logic [1:0]     kind;
        logic [TSW-1:0] ts;
        logic [FW-1:0]  field;
        string          tag;
    } exp_rec_t;
    exp_rec_t sbq[$];

    int checks = 0;
    int errors = 0;
    int n_single = 0, n_multi = 0, n_loss = 0;
    bit hold_low = 1'b0;
    int rpat = 0;
    bit done = 1'b0;
    logic [TSW-1:0] tb_ts;

    always #10 clk = ~clk;   // 50 MHz

    link_err_logger #(.W(W), .TSW(TSW), .LENW(LENW), .CNTW(CNTW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .lock_i       (lock),
        .word_vld_i   (vld),
        .rx_word_i    (rx_w),
        .exp_word_i   (exp_w),
        .rec_ready_i  (rec_ready),
        .rec_valid_o  (rec_valid),
        .rec_kind_o   (rec_kind),
        .rec_time_o   (rec_time),
        .rec_field_o  (rec_field),
        .overflow_o   (overflow),
        .cnt_single_o (cnt_single),
        .cnt_multi_o  (cnt_multi),
        .cnt_loss_o   (cnt_loss)
    );

    // Expected timestamp per R10: 0 after reset, +1 per clock
    always @(posedge clk) begin
        if (rst) tb_ts <= '0;
        else     tb_ts <= tb_ts + TSW'(1);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic word(input bit lk, input bit v, input logic [W-1:0] rx,
                        input logic [W-1:0] ex);
        @(posedge clk);
        #1;
        lock  = lk;
        vld   = v;
        rx_w  = rx;
        exp_w = ex;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) word(1'b1, 1'b0, '0, '0);
    endtask

    task automatic push(input logic [1:0] k, input logic [TSW-1:0] t,
                        input logic [FW-1:0] f, input string tag);
        exp_rec_t e;
        e.kind = k; e.ts = t; e.field = f; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Ready pattern: never low on two consecutive edges, unless held
    always @(posedge clk) begin
        #1;
        rec_ready = hold_low ? 1'b0 : (rpat != 0);
        rpat = (rpat == 2) ? 0 : rpat + 1;
    end

    // Monitor: pops the scoreboard on each completed handshake
    always @(negedge clk) begin
        if (!rst && rec_valid && rec_ready) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R5", "unexpected record kind", rec_kind, 0);
            end else begin
                exp_rec_t e;
                e = sbq.pop_front();
                check(rec_kind == e.kind, e.tag, "kind", rec_kind, e.kind);
                check(rec_time == e.ts, "R10", "timestamp", rec_time, e.ts);
                check(rec_field == e.field, e.tag, "field", rec_field, e.field);
            end
        end
    end

    // One single-flip event at bit idx of PAT (R2)
    task automatic single_evt(input int idx, input bit expect_rec);
        logic [TSW-1:0] t;
        logic [FW-1:0]  f;
        word(1'b1, 1'b1, PAT ^ (W'(1) << idx), PAT);
        t = tb_ts;
        word(1'b1, 1'b1, PAT, PAT);
        f = FW'({PAT[idx], 5'(idx)});
        if (expect_rec) push(2'd1, t, f, "R2");
        n_single++;
    endtask

    task automatic drain();
        idle(8);
        check(sbq.size() == 0, "R7", "records outstanding", sbq.size(), 0);
    endtask

    initial begin
        logic [TSW-1:0] t;
        logic [FW-1:0]  hold_field;
        logic [TSW-1:0] hold_time;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rec_valid == 1'b0, "R1", "valid after reset", rec_valid, 0);
        check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
        check(cnt_single == 0 && cnt_multi == 0 && cnt_loss == 0, "R1",
              "counters after reset", cnt_single + cnt_multi + cnt_loss, 0);
        idle(2);

        // R2: both directions, several positions
        single_evt(1, 1'b1);   // expected 1, received 0
        single_evt(31, 1'b1);  // expected 0, received 1
        single_evt(28, 1'b1);
        drain();

        // R11: strobe gap between bad word and clean word
        word(1'b1, 1'b1, PAT ^ 32'h0000_0001, PAT);
        t = tb_ts;
        word(1'b1, 1'b0, '0, '0);
        word(1'b1, 1'b0, '1, '0);
        word(1'b1, 1'b0, '0, '0);
        word(1'b1, 1'b1, CLEAN, CLEAN);
        push(2'd1, t, FW'({1'b0, 5'd0}), "R11");
        n_single++;
        drain();

        // R3: multi flips
        word(1'b1, 1'b1, PAT ^ 32'h8001_0004, PAT);
        t = tb_ts;
        word(1'b1, 1'b1, CLEAN, CLEAN);
        push(2'd2, t, FW'(3), "R3");
        n_multi++;
        word(1'b1, 1'b1, ~PAT, PAT);
        t = tb_ts;
        word(1'b1, 1'b1, CLEAN, CLEAN);
        push(2'd2, t, FW'(32), "R3");
        n_multi++;
        drain();

        // R4: frame loss of 5 words ended by a clean word
        for (int i = 0; i < 5; i++) begin
            word(1'b1, 1'b1, PAT ^ (W'(3) << i), PAT);
            if (i == 0) t = tb_ts;
        end
        word(1'b1, 1'b1, PAT, PAT);
        push(2'd3, t, FW'(5), "R4");
        n_loss++;
        drain();

        // R11: frame loss of 4 with gaps inside the run
        for (int i = 0; i < 4; i++) begin
            word(1'b1, 1'b1, PAT ^ 32'h0100_0000, PAT);
            if (i == 0) t = tb_ts;
            word(1'b1, 1'b0, '0, '1);
        end
        word(1'b1, 1'b1, PAT, PAT);
        push(2'd3, t, FW'(4), "R11");
        n_loss++;
        drain();

        // R5: lock drop ends a frame loss of 3
        for (int i = 0; i < 3; i++) begin
            word(1'b1, 1'b1, PAT ^ 32'h0000_0F00, PAT);
            if (i == 0) t = tb_ts;
        end
        word(1'b0, 1'b1, PAT ^ 32'h0000_0F00, PAT);
        push(2'd3, t, FW'(3), "R5");
        n_loss++;
        drain();

        // R5: pending word discarded on lock drop; unlocked bad words ignored
        word(1'b1, 1'b1, PAT ^ 32'h0000_0010, PAT);
        word(1'b0, 1'b1, PAT ^ 32'h0000_0030, PAT);
        word(1'b0, 1'b1, ~PAT, PAT);
        word(1'b0, 1'b1, PAT ^ 32'h0000_0001, PAT);
        word(1'b1, 1'b1, CLEAN, CLEAN);
        word(1'b1, 1'b1, CLEAN, CLEAN);
        idle(4);
        @(negedge clk);
        check(rec_valid == 1'b0, "R5", "record after unlocked errors", rec_valid, 0);
        check(cnt_single == CNTW'(n_single), "R5", "single count", cnt_single, n_single);
        check(cnt_multi == CNTW'(n_multi), "R5", "multi count", cnt_multi, n_multi);
        drain();

        // R6: run length saturates at 63
        for (int i = 0; i < 70; i++) begin
            word(1'b1, 1'b1, PAT ^ 32'h0000_4000, PAT);
            if (i == 0) t = tb_ts;
        end
        word(1'b1, 1'b1, PAT, PAT);
        push(2'd3, t, FW'(63), "R6");
        n_loss++;
        drain();

        // R9: many singles push the single counter into saturation
        for (int i = 0; i < 16; i++) single_evt(i, 1'b1);
        drain();
        check(cnt_single == 4'd15, "R9", "single counter saturated", cnt_single, 15);

        // R7 / R8: backpressure and overflow
        hold_low = 1'b1;
        idle(3);
        single_evt(3, 1'b1);
        idle(1);
        @(negedge clk);
        check(rec_valid == 1'b1, "R7", "record waiting", rec_valid, 1);
        hold_field = rec_field;
        hold_time  = rec_time;
        idle(3);
        @(negedge clk);
        check(rec_field == hold_field && rec_time == hold_time, "R7",
              "held field", rec_field, hold_field);
        single_evt(5, 1'b0);   // dropped
        idle(1);
        @(negedge clk);
        check(overflow == 1'b1, "R8", "overflow set", overflow, 1);
        check(rec_field == hold_field, "R8", "first record kept", rec_field, hold_field);
        hold_low = 1'b0;
        drain();
        @(negedge clk);
        check(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);

        // R9: final tallies
        check(cnt_single == CNTW'((n_single > 15) ? 15 : n_single), "R9",
              "single counter", cnt_single, (n_single > 15) ? 15 : n_single);
        check(cnt_multi == CNTW'(n_multi), "R9", "multi counter", cnt_multi, n_multi);
        check(cnt_loss == CNTW'(n_loss), "R9", "loss counter", cnt_loss, n_loss);

        // R1: reset again clears everything
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(overflow == 1'b0, "R1", "overflow cleared", overflow, 0);
        check(cnt_single == 0 && cnt_loss == 0, "R1", "counters cleared",
              cnt_single + cnt_loss, 0);
        check(rec_valid == 1'b0, "R1", "valid cleared", rec_valid, 0);

        // R10: timestamp restarts from zero
        idle(1);
        word(1'b1, 1'b1, PAT ^ 32'h0000_0002, PAT);
        t = tb_ts;
        word(1'b1, 1'b1, PAT, PAT);
        push(2'd1, t, FW'({1'b1, 5'd1}), "R10");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule